// File: doc/BRIEF.md
# Cipher Operand Register File with Inverting Scan Chain

This block holds every operand and handshake bit that a 128-bit block cipher engine needs: the key, the block to encrypt, the block to decrypt, both results, three start strobes and three completion flags. Software reaches it through a narrow word bus with an enable, a write/read select, a word address and a data word. The engine side sees the key and both source blocks as wide outputs, receives one-cycle start strobes, and returns completion pulses along with its result blocks.

For manufacturing test, every storage bit is also one stage of a single serial shift path. A fixed, build-time mask places an inverter in front of chosen stages. Data scanned out is therefore partly complemented, so a tester that does not know the mask cannot read the key off the chain. Bus and engine behaviour are the same whatever the mask is. A two-state mode machine sits in front of the storage. `MODE_FUNC` leads to `MODE_SHIFT` on a clock edge where `scan_enable` is high, and `MODE_SHIFT` leads back to `MODE_FUNC` on a clock edge where `scan_enable` is low. Each of these transition edges is a guard edge: nothing is stored on it.

Top module: `sreg_flip_scan_regs`

## Requirements
- R1: After the asynchronous active-low reset, every storage bit is 0, so every read returns 0, `scan_out` is 0 and all three start strobes are low.
- R2: The word address map has W = BLK_W/WORD_W words per block, each block stored low word first. The key is at words 0..W-1 and the encrypt source at W..2W-1. The encrypt result is at 2W..3W-1, the decrypt source at 3W..4W-1 and the decrypt result at 4W..5W-1. The control word is at 5W; with the defaults these are words 0–3, 4–7, 8–11, 12–15, 16–19 and 20. A bus write (bus_en and bus_wr high) in `MODE_FUNC` with `scan_enable` low updates a key or source word on that clock edge. A read (bus_en high, bus_wr low) returns the addressed word combinationally.
- R3: Addresses above 5W read as 0, and writes to them change nothing.
- R4: The result words are read-only from the bus. So are the completion bits of the control word.
- R5: The control word layout is: bit 0 start key expansion, bit 1 start encrypt, bit 2 start decrypt, bit 4 key done, bit 5 encrypt done, bit 6 decrypt done. All other bits read 0. Writing 1 to a start bit raises that strobe for exactly one cycle; the next functional edge clears it.
- R6: A completion pulse from the engine sets the matching done bit. The encrypt pulse also loads `core_enc_res` into the encrypt result, and the decrypt pulse loads `core_dec_res` into the decrypt result. Writing 1 to a start bit clears the matching done bit; if the completion pulse arrives on the same edge, the done bit stays set.
- R7: The mode machine works as follows. On an edge in `MODE_FUNC` with `scan_enable` high, and on an edge in `MODE_SHIFT` with `scan_enable` low, the machine changes mode and all storage holds. The chain shifts only on edges in `MODE_SHIFT` with `scan_enable` high.
- R8: The chain is ordered scan_in → key (bit 0 first) → encrypt source → decrypt source → encrypt result → decrypt result → start decrypt → start encrypt → start key → decrypt done → encrypt done → key done → scan_out. Stage i loads the previous stage (or scan_in for i = 0) XOR mask bit i.
- R9: With an all-zero mask, the bits seen at `scan_out` before each shift are the stored bits, last stage first. With a mask, the bit stored at stage j appears after L-1-j shifts, XORed with the mask bits j+1 .. L-1, where L = 5·BLK_W + 6.
- R10: The mask has no effect on bus reads, bus writes or engine-side outputs.
- R11: While `scan_enable` is high or the machine is in `MODE_SHIFT`, bus writes and engine completion pulses change nothing.
- R12: `bus_rdata` is 0 whenever `bus_en` is low or `bus_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Bus access enable |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | WORD_W | Write data |
| bus_rdata | output | WORD_W | Read data |
| scan_enable | input | 1 | Test shift request |
| scan_in | input | 1 | Serial chain input |
| scan_out | output | 1 | Serial chain output (last stage) |
| core_key | output | BLK_W | Key block to the engine |
| core_enc_src | output | BLK_W | Block to encrypt |
| core_dec_src | output | BLK_W | Block to decrypt |
| core_go_key | output | 1 | Start key expansion strobe |
| core_go_enc | output | 1 | Start encrypt strobe |
| core_go_dec | output | 1 | Start decrypt strobe |
| core_fin_key | input | 1 | Key expansion finished pulse |
| core_fin_enc | input | 1 | Encrypt finished pulse |
| core_fin_dec | input | 1 | Decrypt finished pulse |
| core_enc_res | input | BLK_W | Encrypt result |
| core_dec_res | input | BLK_W | Decrypt result |

## Verification
The assertions assume that every input is synchronous to `clk` and steady around the rising edge. They also assume that completion pulses and bus writes are meaningful only in functional mode. The stall, shift-head and shift-tail properties hold only if `scan_enable` switches between edges and does not glitch within a cycle. The stimulus meets these assumptions by changing every input just after the falling edge and keeping reads combinational within the low half-cycle. Scan entry and exit are always driven as whole-cycle levels, so each mode change gets its guard edge.

// File: rtl/sreg_pkg.sv
`timescale 1ns/10ps
package sreg_pkg;

    typedef enum logic [0:0] {
        MODE_FUNC  = 1'b0,
        MODE_SHIFT = 1'b1
    } scan_mode_e;

    localparam int NUM_BLK = 5;
    localparam int TAIL_W  = 6;

    // offsets of the single-bit cells after the five blocks, in chain order
    localparam int TAIL_GO_DEC  = 0;
    localparam int TAIL_GO_ENC  = 1;
    localparam int TAIL_GO_KEY  = 2;
    localparam int TAIL_FIN_DEC = 3;
    localparam int TAIL_FIN_ENC = 4;
    localparam int TAIL_FIN_KEY = 5;

    // bit positions inside the control word
    localparam int CTL_GO_KEY  = 0;
    localparam int CTL_GO_ENC  = 1;
    localparam int CTL_GO_DEC  = 2;
    localparam int CTL_FIN_KEY = 4;
    localparam int CTL_FIN_ENC = 5;
    localparam int CTL_FIN_DEC = 6;

    localparam int MASK_POOL_W = 1024;

    // address block -> chain block (source/result blocks swap order in the chain)
    function automatic int chain_blk(input int ab);
        case (ab)
            2:       return 3;
            3:       return 2;
            default: return ab;
        endcase
    endfunction

    // key, encrypt source and decrypt source are bus-writable
    function automatic bit blk_writable(input int ab);
        return (ab == 0) || (ab == 1) || (ab == 3);
    endfunction

    // xorshift expansion of a seed into a default inverter mask
    function automatic logic [MASK_POOL_W-1:0] expand_mask(input logic [31:0] seed);
        logic [31:0]            s;
        logic [MASK_POOL_W-1:0] r;
        s = seed;
        r = '0;
        for (int k = 0; k < MASK_POOL_W / 32; k++) begin
            s = s ^ (s << 13);
            s = s ^ (s >> 17);
            s = s ^ (s << 5);
            r[k*32 +: 32] = s;
        end
        return r;
    endfunction

endpackage

// File: rtl/sreg_mode_fsm.sv
`timescale 1ns/10ps
module sreg_mode_fsm
    import sreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scan_enable,
    output logic shift_en,
    output logic func_en
);

    scan_mode_e mode_q;
    scan_mode_e mode_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_FUNC;
        else        mode_q <= mode_d;
    end

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_FUNC:  if (scan_enable)  mode_d = MODE_SHIFT;
            MODE_SHIFT: if (!scan_enable) mode_d = MODE_FUNC;
            default:    mode_d = MODE_FUNC;
        endcase
    end

    always_comb begin
        shift_en = 1'b0;
        func_en  = 1'b0;
        unique case (mode_q)
            MODE_FUNC:  func_en  = !scan_enable;
            MODE_SHIFT: shift_en = scan_enable;
            default:    ;
        endcase
    end

    // R7
    mode_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |-> $past(scan_enable));

endmodule

// File: rtl/sreg_func_next.sv
`timescale 1ns/10ps
module sreg_func_next
    import sreg_pkg::*;
#(
    parameter int BLK_W  = 128,
    parameter int WORD_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic [NUM_BLK*BLK_W+TAIL_W-1:0] q_cur,
    input  logic                            wr_hit,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [WORD_W-1:0]               wdata,
    input  logic                            fin_key,
    input  logic                            fin_enc,
    input  logic                            fin_dec,
    input  logic [BLK_W-1:0]                enc_res,
    input  logic [BLK_W-1:0]                dec_res,
    output logic [NUM_BLK*BLK_W+TAIL_W-1:0] q_nxt
);

    localparam int WPB      = BLK_W / WORD_W;
    localparam int CTL_ADDR = NUM_BLK * WPB;
    localparam int TB       = NUM_BLK * BLK_W;

    logic ctl_wr;
    assign ctl_wr = wr_hit && (addr == ADDR_W'(CTL_ADDR));

    always_comb begin
        q_nxt = q_cur;
        for (int a = 0; a < CTL_ADDR; a++) begin
            if (wr_hit && (addr == ADDR_W'(a)) && blk_writable(a / WPB))
                q_nxt[chain_blk(a / WPB)*BLK_W + (a % WPB)*WORD_W +: WORD_W] = wdata;
        end
        // start strobes: last one cycle unless rewritten
        q_nxt[TB+TAIL_GO_KEY] = ctl_wr && wdata[CTL_GO_KEY];
        q_nxt[TB+TAIL_GO_ENC] = ctl_wr && wdata[CTL_GO_ENC];
        q_nxt[TB+TAIL_GO_DEC] = ctl_wr && wdata[CTL_GO_DEC];
        // done flags: cleared by a start write, set by completion (set wins)
        if (ctl_wr && wdata[CTL_GO_KEY]) q_nxt[TB+TAIL_FIN_KEY] = 1'b0;
        if (ctl_wr && wdata[CTL_GO_ENC]) q_nxt[TB+TAIL_FIN_ENC] = 1'b0;
        if (ctl_wr && wdata[CTL_GO_DEC]) q_nxt[TB+TAIL_FIN_DEC] = 1'b0;
        if (fin_key) q_nxt[TB+TAIL_FIN_KEY] = 1'b1;
        if (fin_enc) begin
            q_nxt[TB+TAIL_FIN_ENC]       = 1'b1;
            q_nxt[3*BLK_W +: BLK_W]      = enc_res;
        end
        if (fin_dec) begin
            q_nxt[TB+TAIL_FIN_DEC]       = 1'b1;
            q_nxt[4*BLK_W +: BLK_W]      = dec_res;
        end
    end

endmodule

// File: rtl/sreg_chain_store.sv
`timescale 1ns/10ps
module sreg_chain_store #(
    parameter int             L         = 646,
    parameter logic [L-1:0]   FLIP_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         func_en,
    input  logic         scan_in,
    input  logic [L-1:0] q_nxt,
    output logic [L-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= '0;
        else if (shift_en) q <= {q[L-2:0], scan_in} ^ FLIP_MASK;
        else if (func_en)  q <= q_nxt;
    end

    // R8
    shift_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (q[0] == ($past(scan_in) ^ FLIP_MASK[0])));

    // R8
    shift_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (q[L-1] == ($past(q[L-2]) ^ FLIP_MASK[L-1])));

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !func_en) |=> $stable(q));

endmodule

// File: rtl/sreg_flip_scan_regs.sv
`timescale 1ns/10ps
module sreg_flip_scan_regs
    import sreg_pkg::*;
#(
    parameter int BLK_W  = 128,
    parameter int WORD_W = 32,
    parameter int ADDR_W = 5,
    parameter logic [NUM_BLK*BLK_W+TAIL_W-1:0] FLIP_MASK =
        (NUM_BLK*BLK_W+TAIL_W)'(expand_mask(32'h9E37_79B9))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              scan_enable,
    input  logic              scan_in,
    output logic              scan_out,
    output logic [BLK_W-1:0]  core_key,
    output logic [BLK_W-1:0]  core_enc_src,
    output logic [BLK_W-1:0]  core_dec_src,
    output logic              core_go_key,
    output logic              core_go_enc,
    output logic              core_go_dec,
    input  logic              core_fin_key,
    input  logic              core_fin_enc,
    input  logic              core_fin_dec,
    input  logic [BLK_W-1:0]  core_enc_res,
    input  logic [BLK_W-1:0]  core_dec_res
);

    localparam int L        = NUM_BLK * BLK_W + TAIL_W;
    localparam int WPB      = BLK_W / WORD_W;
    localparam int CTL_ADDR = NUM_BLK * WPB;
    localparam int TB       = NUM_BLK * BLK_W;

    logic         shift_en;
    logic         func_en;
    logic         wr_hit;
    logic         ctl_wr;
    logic [L-1:0] q;
    logic [L-1:0] q_nxt;

    assign wr_hit = bus_en && bus_wr;
    assign ctl_wr = wr_hit && (bus_addr == ADDR_W'(CTL_ADDR));

    sreg_mode_fsm u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .scan_enable (scan_enable),
        .shift_en    (shift_en),
        .func_en     (func_en)
    );

    sreg_func_next #(.BLK_W(BLK_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_next (
        .q_cur   (q),
        .wr_hit  (wr_hit),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .fin_key (core_fin_key),
        .fin_enc (core_fin_enc),
        .fin_dec (core_fin_dec),
        .enc_res (core_enc_res),
        .dec_res (core_dec_res),
        .q_nxt   (q_nxt)
    );

    sreg_chain_store #(.L(L), .FLIP_MASK(FLIP_MASK)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .func_en  (func_en),
        .scan_in  (scan_in),
        .q_nxt    (q_nxt),
        .q        (q)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_wr) begin
            for (int a = 0; a < CTL_ADDR; a++) begin
                if (bus_addr == ADDR_W'(a))
                    bus_rdata = q[chain_blk(a / WPB)*BLK_W + (a % WPB)*WORD_W +: WORD_W];
            end
            if (bus_addr == ADDR_W'(CTL_ADDR)) begin
                bus_rdata[CTL_GO_KEY]  = q[TB+TAIL_GO_KEY];
                bus_rdata[CTL_GO_ENC]  = q[TB+TAIL_GO_ENC];
                bus_rdata[CTL_GO_DEC]  = q[TB+TAIL_GO_DEC];
                bus_rdata[CTL_FIN_KEY] = q[TB+TAIL_FIN_KEY];
                bus_rdata[CTL_FIN_ENC] = q[TB+TAIL_FIN_ENC];
                bus_rdata[CTL_FIN_DEC] = q[TB+TAIL_FIN_DEC];
            end
        end
    end

    assign scan_out     = q[L-1];
    assign core_key     = q[0       +: BLK_W];
    assign core_enc_src = q[BLK_W   +: BLK_W];
    assign core_dec_src = q[2*BLK_W +: BLK_W];
    assign core_go_key  = q[TB+TAIL_GO_KEY];
    assign core_go_enc  = q[TB+TAIL_GO_ENC];
    assign core_go_dec  = q[TB+TAIL_GO_DEC];

    // R3
    oor_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_wr && (bus_addr > ADDR_W'(CTL_ADDR))) |-> (bus_rdata == '0));

    // R5
    go_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_go_key |=> (!core_go_key || $past(ctl_wr && bus_wdata[CTL_GO_KEY]) || $past(!func_en)));

    // R6
    fin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q[TB+TAIL_FIN_KEY] && func_en && !(ctl_wr && bus_wdata[CTL_GO_KEY])) |=> q[TB+TAIL_FIN_KEY]);

endmodule

// File: tb/sreg_flip_scan_regs_tb.sv
`timescale 1ns/10ps
module sreg_flip_scan_regs_tb_top;

    localparam int BW   = 16;
    localparam int WW   = 8;
    localparam int AW   = 4;
    localparam int L    = 5*BW + 6;
    localparam int CTLA = 10;
    localparam logic [L-1:0] BMASK = 86'h25A5AC3C30F0F124884219;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_en = 1'b0, bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [WW-1:0] bus_wdata = '0;
    logic scan_enable = 1'b0, scan_in = 1'b0;
    logic fin_key = 1'b0, fin_enc = 1'b0, fin_dec = 1'b0;
    logic [BW-1:0] enc_res = '0, dec_res = '0;

    logic [WW-1:0] rd, rd_p;
    logic so, so_p;
    logic [BW-1:0] key, key_p, esrc, esrc_p, dsrc, dsrc_p;
    logic gk, ge, gd, gk_p, ge_p, gd_p;

    int n_chk = 0;
    int n_err = 0;
    logic [L-1:0] mdl = '0;
    logic [L-1:0] mdl_p = '0;

    always #4 clk = ~clk;

    sreg_flip_scan_regs #(.BLK_W(BW), .WORD_W(WW), .ADDR_W(AW), .FLIP_MASK(BMASK)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd), .scan_enable(scan_enable), .scan_in(scan_in),
        .scan_out(so), .core_key(key), .core_enc_src(esrc), .core_dec_src(dsrc),
        .core_go_key(gk), .core_go_enc(ge), .core_go_dec(gd), .core_fin_key(fin_key),
        .core_fin_enc(fin_enc), .core_fin_dec(fin_dec), .core_enc_res(enc_res),
        .core_dec_res(dec_res));

    sreg_flip_scan_regs #(.BLK_W(BW), .WORD_W(WW), .ADDR_W(AW), .FLIP_MASK('0)) dut_plain_i (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_p), .scan_enable(scan_enable), .scan_in(scan_in),
        .scan_out(so_p), .core_key(key_p), .core_enc_src(esrc_p), .core_dec_src(dsrc_p),
        .core_go_key(gk_p), .core_go_enc(ge_p), .core_go_dec(gd_p), .core_fin_key(fin_key),
        .core_fin_enc(fin_enc), .core_fin_dec(fin_dec), .core_enc_res(enc_res),
        .core_dec_res(dec_res));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // R2 address map: chain block of an address block (result/source swap)
    function automatic int cblk(input int ab);
        return (ab == 2) ? 3 : (ab == 3) ? 2 : ab;
    endfunction

    // R2/R3/R5 expected read value of word a for storage image v
    function automatic logic [WW-1:0] exp_word(input logic [L-1:0] v, input int a);
        if (a < CTLA) return v[cblk(a/2)*BW + (a%2)*WW +: WW];
        if (a == CTLA) return {1'b0, v[L-3], v[L-2], v[L-1], 1'b0, v[L-6], v[L-5], v[L-4]};
        return '0;
    endfunction

    function automatic logic xr(input logic [L-1:0] m, input int lo, input int hi);
        logic r;
        r = 1'b0;
        for (int j = lo; j <= hi; j++) r = r ^ m[j];
        return r;
    endfunction

    task automatic rd_chk(input int a, input string req);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = AW'(a);
        #0.1;
        check(req, 32'(rd), 32'(exp_word(mdl, a)));
        check({req, " R10"}, 32'(rd_p), 32'(exp_word(mdl_p, a)));
    endtask

    task automatic rd_all(input string req);
        for (int a = 0; a < 16; a++) rd_chk(a, req);
        bus_en = 1'b0;
    endtask

    task automatic wr(input int a, input logic [WW-1:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
        @(negedge clk);
        if (a < CTLA) begin
            if ((a/2) != 2 && (a/2) != 4) begin
                mdl[cblk(a/2)*BW + (a%2)*WW +: WW]   = d;
                mdl_p[cblk(a/2)*BW + (a%2)*WW +: WW] = d;
            end
        end else if (a == CTLA) begin
            if (d[0]) begin mdl[L-1] = 1'b0; mdl_p[L-1] = 1'b0; end
            if (d[1]) begin mdl[L-2] = 1'b0; mdl_p[L-2] = 1'b0; end
            if (d[2]) begin mdl[L-3] = 1'b0; mdl_p[L-3] = 1'b0; end
        end
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [L-1:0] orig;
        logic [L-1:0] tgt;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_all("R1 reset read");
        check("R1 scan_out", 32'(so), 32'h0);
        check("R1 go strobes", 32'({gk, ge, gd, gk_p, ge_p, gd_p}), 32'h0);

        // R2 R3 R4 sweep of every address with a computed pattern
        for (int a = 0; a < 16; a++) wr(a, WW'(a*37 + 5));
        rd_all("R2 R3 R4 sweep readback");
        check("R10 key out", 32'(key), 32'(key_p));
        check("R10 enc src out", 32'(esrc), 32'(esrc_p));
        check("R10 dec src out", 32'(dsrc), 32'(dsrc_p));
        check("R2 key out", 32'(key), 32'(mdl[0 +: BW]));

        // R12 no read data when disabled or writing
        bus_en = 1'b0; bus_wr = 1'b0; bus_addr = 4'd0; #0.1;
        check("R12 en low", 32'(rd), 32'h0);
        bus_en = 1'b1; bus_wr = 1'b1; #0.1;
        check("R12 write cycle", 32'(rd), 32'h0);
        bus_en = 1'b0; bus_wr = 1'b0;

        // R5 start strobes last one cycle
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = AW'(CTLA); bus_wdata = 8'h05;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
        check("R5 strobe high", 32'({gk, ge, gd}), 32'b101);
        check("R5 strobe high R10", 32'({gk_p, ge_p, gd_p}), 32'b101);
        @(negedge clk);
        check("R5 strobe cleared", 32'({gk, ge, gd, gk_p, ge_p, gd_p}), 32'h0);

        // R6 completion pulses
        @(negedge clk); fin_enc = 1'b1; enc_res = 16'hBEEF;
        @(negedge clk); fin_enc = 1'b0; fin_dec = 1'b1; dec_res = 16'h1234;
        @(negedge clk); fin_dec = 1'b0; fin_key = 1'b1;
        @(negedge clk); fin_key = 1'b0;
        mdl[3*BW +: BW] = 16'hBEEF; mdl_p[3*BW +: BW] = 16'hBEEF;
        mdl[4*BW +: BW] = 16'h1234; mdl_p[4*BW +: BW] = 16'h1234;
        mdl[L-3 +: 3] = 3'b111; mdl_p[L-3 +: 3] = 3'b111;
        rd_all("R6 completion load");
        check("R6 ctrl all done", 32'(exp_word(mdl, CTLA)), 32'h70);
        wr(CTLA, 8'h02);
        rd_chk(CTLA, "R6 enc done cleared");
        check("R6 ctrl after clear", 32'(rd), 32'h50);
        bus_en = 1'b0;
        // R6 completion and start on the same edge: done stays set
        @(negedge clk);
        fin_key = 1'b1; bus_en = 1'b1; bus_wr = 1'b1; bus_addr = AW'(CTLA); bus_wdata = 8'h01;
        @(negedge clk);
        fin_key = 1'b0; bus_en = 1'b0; bus_wr = 1'b0;
        @(negedge clk);
        rd_chk(CTLA, "R6 set wins");
        bus_en = 1'b0;
        wr(CTLA, 8'h01);
        rd_chk(CTLA, "R6 key done cleared");
        check("R6 ctrl only dec done", 32'(rd), 32'h40);
        bus_en = 1'b0;

        // R7 R11 guard edges on entry and exit block writes and completions
        @(negedge clk);
        scan_enable = 1'b1;
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = 4'd0; bus_wdata = 8'hFF;
        fin_enc = 1'b1; enc_res = 16'h0000;
        @(negedge clk);
        scan_enable = 1'b0;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0; fin_enc = 1'b0;
        rd_all("R7 R11 guard edges hold");

        // R9 scan dump of the stored image
        orig = mdl;
        @(negedge clk);
        scan_enable = 1'b1; scan_in = 1'b0;
        @(negedge clk);
        for (int k = 0; k < L; k++) begin
            check("R9 R8 flipped scan_out", 32'(so),
                  32'(orig[L-1-k] ^ ((k == 0) ? 1'b0 : xr(BMASK, L-k, L-1))));
            check("R9 plain scan_out", 32'(so_p), 32'(orig[L-1-k]));
            @(negedge clk);
        end

        // R8 serial load of a chosen image through the flipped chain
        tgt = {1'b1, 1'b0, 1'b1, 3'b000, 16'h2468, 16'h9BDF, 16'h1357, 16'h0FF0, 16'hA5C3};
        for (int t = 0; t < L; t++) begin
            scan_in = tgt[L-1-t] ^ xr(BMASK, 0, L-1-t);
            @(negedge clk);
        end
        scan_enable = 1'b0; scan_in = 1'b0;
        @(negedge clk);
        mdl = tgt;
        for (int i = 0; i < L; i++) mdl_p[i] = tgt[i] ^ xr(BMASK, 0, i);
        rd_all("R8 serial load readback");
        check("R8 key out", 32'(key), 32'hA5C3);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule